// File: doc/BRIEF.md
# Parallel Configuration Bus-Width Detector

This block sits at the front of a configuration data path and watches a 32-bit parallel data port. In parallel operation it first works out how wide the external bus is. It does this from a two-byte marker that arrives on the lowest byte lane. It then builds 32-bit words out of the incoming beats at that width and hunts for a fixed synchronization word. Only after that word has been matched does it hand aligned 32-bit words to the downstream packet logic.

Every byte lane arrives with its bits mirrored: pin bit 0 of a lane carries bit 7 of the byte. The block un-mirrors every lane before it compares or assembles anything, so all values below are in the unswapped form unless they are stated as pin values. In serial operation the width search is skipped and the block runs with one byte per beat.

Top module: `cfg_bus_width_det`

## Requirements
- R1: When reset is asserted, `width_o` reads 0, `sync_o` reads 0 and `word_valid_o` reads 0.
- R2: Each byte lane is bit-reversed before it is used: pin bit `8*n+k` maps to byte bit `8*n+7-k`. For example, the pin value 0x5599AA66 on a 32-bit beat is taken as the word 0xAA995566.
- R3: In parallel mode (`par_mode_i`=1), a beat whose lane 0 holds 0xBB, followed by a beat whose lane 0 holds 0x11, 0x22 or 0x44, sets `width_o` to 1 (8-bit), 2 (16-bit) or 3 (32-bit) respectively. The width is visible in the cycle after the code beat.
- R4: If the byte after 0xBB is neither a width code nor 0xBB, the detector drops back to searching, and a later lone code byte does not set a width. A second 0xBB in that slot keeps the detector armed for the next byte.
- R5: Pad bytes 0x00 and 0xFF while searching leave `width_o` at 0. Beats with `data_valid_i` low have no effect on any state.
- R6: In serial mode (`par_mode_i`=0), `width_o` becomes 1 after reset without any marker. Marker pairs that arrive later do not change it.
- R7: The sync search does not run until a width is fixed. A sync word that arrives before the marker pair leaves `sync_o` low.
- R8: At 8-bit and 16-bit width, the sync search slides one beat at a time, so the sync word is found at any beat offset. `sync_o` rises in the cycle after the beat that completes 0xAA995566.
- R9: `word_valid_o` is never high while `sync_o` is low. Once `sync_o` is set it stays set until reset.
- R10: After a sync match, word assembly starts with the next beat. The first beat lands in the most significant bits, and a word is emitted after 4, 2 or 1 beats at 8, 16 or 32-bit width. `word_valid_o` pulses for one cycle after the final beat, with the word on `word_o`.
- R11: Once a width is fixed, further marker pairs do not change `width_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_mode_i | input | 1 | 1 = parallel operation, 0 = serial operation |
| data_valid_i | input | 1 | Qualifies `data_i` for one beat |
| data_i | input | 32 | Pin-order data; lane 0 is bits 7:0 |
| width_o | output | 2 | 0 none, 1 = 8-bit, 2 = 16-bit, 3 = 32-bit |
| sync_o | output | 1 | Sync word matched |
| word_o | output | 32 | Aligned, unswapped 32-bit word |
| word_valid_o | output | 1 | One-cycle strobe for `word_o` |

## Verification
The hardest situation to reach from the ports is a sync word that straddles beat boundaries. A second hard case is a marker stream that disarms and re-arms the detector before it locks. The stimulus reaches the first by sending one filler beat after locking at 8-bit and 16-bit width, so that the sync word is shifted off a word boundary. It reaches the second by sending 0xBB followed by a bad code, then a lone code, then two back-to-back 0xBB bytes. A copy of the sync word sent before any marker, and one sent with the valid strobe low, show that no early match can happen.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANES  = WORD_W / BYTE_W;

  localparam logic [BYTE_W-1:0] MARK_BYTE = 8'hBB;
  localparam logic [BYTE_W-1:0] CODE_X8   = 8'h11;
  localparam logic [BYTE_W-1:0] CODE_X16  = 8'h22;
  localparam logic [BYTE_W-1:0] CODE_X32  = 8'h44;
  localparam logic [WORD_W-1:0] SYNC_WORD = 32'hAA995566;

  typedef enum logic [1:0] {
    BW_NONE = 2'd0,
    BW_X8   = 2'd1,
    BW_X16  = 2'd2,
    BW_X32  = 2'd3
  } bus_w_e;

  typedef enum logic [1:0] {
    DS_SEEK   = 2'd0,
    DS_ARMED  = 2'd1,
    DS_LOCKED = 2'd2
  } det_st_e;
endpackage

// File: rtl/lane_swap.sv
module lane_swap #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] pin_i,
  output logic [LANES*BYTE_W-1:0] byte_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
      assign byte_o[g*BYTE_W+b] = pin_i[g*BYTE_W+BYTE_W-1-b];
    end
  end
endmodule

// File: rtl/width_detect.sv
module width_detect
  import cfgw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_mode_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] lane0_i,
  output bus_w_e            width_o,
  output logic              locked_o
);
  det_st_e st_q;
  bus_w_e  width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= DS_SEEK;
      width_q <= BW_NONE;
    end else begin
      unique case (st_q)
        DS_SEEK: begin
          if (!par_mode_i) begin
            width_q <= BW_X8;
            st_q    <= DS_LOCKED;
          end else if (valid_i && lane0_i == MARK_BYTE) begin
            st_q <= DS_ARMED;
          end
        end
        DS_ARMED: begin
          if (valid_i) begin
            unique case (lane0_i)
              CODE_X8:   begin width_q <= BW_X8;  st_q <= DS_LOCKED; end
              CODE_X16:  begin width_q <= BW_X16; st_q <= DS_LOCKED; end
              CODE_X32:  begin width_q <= BW_X32; st_q <= DS_LOCKED; end
              MARK_BYTE: st_q <= DS_ARMED;
              default:   st_q <= DS_SEEK;
            endcase
          end
        end
        default: st_q <= DS_LOCKED;
      endcase
    end
  end

  assign width_o  = width_q;
  assign locked_o = (st_q == DS_LOCKED);

  AST_WIDTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(width_q)); // R11
  AST_LOCK_NEEDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && $past(par_mode_i) && $rose(locked_o)) |->
      ($past(st_q) == DS_ARMED && $past(valid_i))); // R3
  AST_UNLOCKED_NO_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> width_q == BW_NONE); // R5
endmodule

// File: rtl/sync_align.sv
module sync_align
  import cfgw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  bus_w_e            width_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              sync_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int unsigned CNT_W = $clog2(LANES);

  logic [WORD_W-1:0] sh_q, sh_d, acc_q, acc_d, word_q;
  logic [CNT_W-1:0]  cnt_q, last_beat;
  logic              sync_q, wv_q;

  // shift one beat of the current width into the low end
  always_comb begin
    unique case (width_i)
      BW_X8: begin
        sh_d      = {sh_q[WORD_W-BYTE_W-1:0], data_i[BYTE_W-1:0]};
        acc_d     = {acc_q[WORD_W-BYTE_W-1:0], data_i[BYTE_W-1:0]};
        last_beat = CNT_W'(LANES - 1);
      end
      BW_X16: begin
        sh_d      = {sh_q[WORD_W-2*BYTE_W-1:0], data_i[2*BYTE_W-1:0]};
        acc_d     = {acc_q[WORD_W-2*BYTE_W-1:0], data_i[2*BYTE_W-1:0]};
        last_beat = CNT_W'(LANES / 2 - 1);
      end
      BW_X32: begin
        sh_d      = data_i;
        acc_d     = data_i;
        last_beat = '0;
      end
      default: begin
        sh_d      = sh_q;
        acc_d     = acc_q;
        last_beat = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      acc_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      sync_q <= 1'b0;
      wv_q   <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (valid_i && en_i) begin
        if (!sync_q) begin
          sh_q <= sh_d;
          if (sh_d == SYNC_WORD) begin
            sync_q <= 1'b1;
            cnt_q  <= '0;
          end
        end else begin
          acc_q <= acc_d;
          if (cnt_q == last_beat) begin
            word_q <= acc_d;
            wv_q   <= 1'b1;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign sync_o       = sync_q;
  assign word_o       = word_q;
  assign word_valid_o = wv_q;

  AST_NO_EARLY_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> sync_o); // R9
  AST_SYNC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_o) |-> sync_o); // R9
  AST_SYNC_AFTER_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> ($past(en_i) && $past(valid_i))); // R7
  AST_WORD_ON_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(valid_i)); // R10
endmodule

// File: rtl/cfg_bus_width_det.sv
module cfg_bus_width_det
  import cfgw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_mode_i,
  input  logic              data_valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [1:0]        width_o,
  output logic              sync_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  logic [WORD_W-1:0] bytes;
  bus_w_e            width;
  logic              locked;

  lane_swap #(.LANES(LANES), .BYTE_W(BYTE_W)) u_swap (
    .pin_i  (data_i),
    .byte_o (bytes)
  );

  width_detect u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_mode_i(par_mode_i),
    .valid_i   (data_valid_i),
    .lane0_i   (bytes[BYTE_W-1:0]),
    .width_o   (width),
    .locked_o  (locked)
  );

  sync_align u_align (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (locked),
    .width_i     (width),
    .valid_i     (data_valid_i),
    .data_i      (bytes),
    .sync_o      (sync_o),
    .word_o      (word_o),
    .word_valid_o(word_valid_o)
  );

  assign width_o = width;

  AST_SERIAL_X8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_mode_i && locked) |-> width_o == 2'd1); // R6
  AST_SYNC_NEEDS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> width_o != 2'd0); // R7
endmodule

// File: tb/sim_cfg_bus_width_det.sv
`timescale 1ns/1ps
module sim_cfg_bus_width_det;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        par_mode = 1'b1;
  logic        dv = 1'b0;
  logic [31:0] din = '0;
  logic [1:0]  width;
  logic        sync;
  logic [31:0] word;
  logic        wv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_bus_width_det u0 (
    .clk_i(clk), .rst_ni(rst_ni), .par_mode_i(par_mode),
    .data_valid_i(dv), .data_i(din),
    .width_o(width), .sync_o(sync), .word_o(word), .word_valid_o(wv)
  );

  function automatic logic [31:0] to_pins(input logic [31:0] w);
    logic [31:0] p;
    for (int i = 0; i < 32; i++) p[(i/8)*8 + 7 - (i%8)] = w[i];
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic par);
    @(negedge clk);
    rst_ni = 1'b0; dv = 1'b0; din = '0; par_mode = par;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one valid beat, unswapped value, converted to pin order
  task automatic beat(input logic [31:0] w);
    @(negedge clk);
    dv = 1'b1; din = to_pins(w);
    @(negedge clk);
    dv = 1'b0; din = '0;
  endtask

  task automatic byte_seq(input logic [7:0] b);
    beat({24'h0, b});
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(width == 2'd0, "R1 width", {30'h0, width}, 0);
    check(sync == 1'b0, "R1 sync", {31'h0, sync}, 0);
    check(wv == 1'b0, "R1 word_valid", {31'h0, wv}, 0);
  endtask

  task automatic t_x8;
    do_reset(1'b1);
    byte_seq(8'hFF); byte_seq(8'h00); byte_seq(8'hFF);
    check(width == 2'd0, "R5 pads keep width 0", {30'h0, width}, 0);
    byte_seq(8'hBB); byte_seq(8'h11);
    check(width == 2'd1, "R3 x8 code", {30'h0, width}, 1);
    // sync bytes with valid low must be ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dv = 1'b0; din = to_pins({24'h0, SYNC_B(i)});
    end
    @(negedge clk); din = '0;
    check(sync == 1'b0, "R5 invalid beats ignored", {31'h0, sync}, 0);
    byte_seq(8'hAA); byte_seq(8'h99); byte_seq(8'h55);
    check(sync == 1'b0, "R8 partial sync", {31'h0, sync}, 0);
    byte_seq(8'h66);
    check(sync == 1'b1, "R8 x8 sync", {31'h0, sync}, 1);
    byte_seq(8'h12); byte_seq(8'h34); byte_seq(8'h56);
    check(wv == 1'b0, "R10 x8 no early word", {31'h0, wv}, 0);
    byte_seq(8'h78);
    check(wv == 1'b1 && word == 32'h12345678, "R10 x8 word", word, 32'h12345678);
    @(negedge clk);
    check(wv == 1'b0, "R10 one-cycle strobe", {31'h0, wv}, 0);
    byte_seq(8'hBB); byte_seq(8'h44);
    check(width == 2'd1, "R11 width sticky", {30'h0, width}, 1);
    check(sync == 1'b1, "R9 sync sticky", {31'h0, sync}, 1);
  endtask

  function automatic logic [7:0] SYNC_B(input int i);
    logic [31:0] s = 32'hAA995566;
    return s[31-8*i -: 8];
  endfunction

  task automatic t_x16;
    do_reset(1'b1);
    byte_seq(8'hBB); byte_seq(8'h22);
    check(width == 2'd2, "R3 x16 code", {30'h0, width}, 2);
    beat(32'h0000_1234); beat(32'h0000_AA99);
    check(sync == 1'b0, "R8 x16 half sync", {31'h0, sync}, 0);
    beat(32'h0000_5566);
    check(sync == 1'b1, "R8 x16 offset sync", {31'h0, sync}, 1);
    beat(32'h0000_DEAD);
    check(wv == 1'b0, "R10 x16 first half", {31'h0, wv}, 0);
    beat(32'h0000_BEEF);
    check(wv == 1'b1 && word == 32'hDEADBEEF, "R10 x16 word", word, 32'hDEADBEEF);
  endtask

  task automatic t_x32;
    do_reset(1'b1);
    byte_seq(8'hBB); byte_seq(8'h44);
    check(width == 2'd3, "R3 x32 code", {30'h0, width}, 3);
    // raw pin value, no bench-side swap
    @(negedge clk); dv = 1'b1; din = 32'h5599AA66;
    @(negedge clk); dv = 1'b0; din = '0;
    check(sync == 1'b1, "R2 pin sync value", {31'h0, sync}, 1);
    beat(32'hCAFEF00D);
    check(wv == 1'b1 && word == 32'hCAFEF00D, "R10 x32 word", word, 32'hCAFEF00D);
  endtask

  task automatic t_rearm;
    do_reset(1'b1);
    byte_seq(8'hBB); byte_seq(8'h33);
    check(width == 2'd0, "R4 bad code", {30'h0, width}, 0);
    byte_seq(8'h22);
    check(width == 2'd0, "R4 lone code after rearm", {30'h0, width}, 0);
    byte_seq(8'hBB); byte_seq(8'hBB); byte_seq(8'h44);
    check(width == 2'd3, "R4 double marker", {30'h0, width}, 3);
  endtask

  task automatic t_early_sync;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) byte_seq(SYNC_B(i));
    check(sync == 1'b0, "R7 sync before width", {31'h0, sync}, 0);
    check(wv == 1'b0, "R9 no word before sync", {31'h0, wv}, 0);
    byte_seq(8'hBB); byte_seq(8'h11);
    byte_seq(8'h01);
    for (int i = 0; i < 4; i++) byte_seq(SYNC_B(i));
    check(sync == 1'b1, "R8 sync after filler", {31'h0, sync}, 1);
  endtask

  task automatic t_serial;
    do_reset(1'b0);
    @(negedge clk);
    check(width == 2'd1, "R6 serial width", {30'h0, width}, 1);
    byte_seq(8'hBB); byte_seq(8'h44);
    check(width == 2'd1, "R6 marker ignored", {30'h0, width}, 1);
    for (int i = 0; i < 4; i++) byte_seq(SYNC_B(i));
    check(sync == 1'b1, "R6 serial sync", {31'h0, sync}, 1);
  endtask

  initial begin
    t_reset();
    t_x8();
    t_x16();
    t_x32();
    t_rearm();
    t_early_sync();
    t_serial();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_600_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule